// File: doc/BRIEF.md
# VCO Band-Select Sequencer

This block picks one of eight overlapping VCO bands by a short binary search that runs before the synthesizer's loop takes over. A search starts on its own when reset is released, and again each time the feedback-divider register is written, which the surrounding logic signals with a one-cycle `start_i` pulse. The search is paced by `ref_tick_i`, a one-cycle enable that marks each reference-divider output edge. A prescaler divides these ticks by 1, 2, 4 or 8, and each prescaled tick is one search step.

A search takes five steps. The first three are a successive approximation from the most significant band bit down to the least. At each of these steps the frequency comparator (`vco_fast_i`) decides the bit on trial. The fourth step lets the VCO settle and the fifth confirms the result. For the whole window, `tune_hold_o` keeps the tuning node tied to the internal reference instead of the loop filter, and `busy_o` is high. Both drop on the same clock edge, and the loop then resumes normal control with the chosen `band_o`.

Top module: `bsel_top`

## Requirements
- R1: Reset leaves `busy_o`=1, `tune_hold_o`=1 and `band_o`=3'b100, which starts a search at once. That power-up search divides ticks by 1, whatever `div_sel_i` is.
- R2: A `start_i` pulse gives `busy_o`=1, `tune_hold_o`=1 and `band_o`=3'b100 on the next edge. This holds when the block is idle and also in the middle of a search, which then begins again from its first step.
- R3: `div_sel_i` encodes the tick division as 2'b00=1, 2'b01=2, 2'b10=4 and 2'b11=8. A step happens on every R-th `ref_tick_i` counted while busy, so one search takes exactly 5·R ticks.
- R4: `div_sel_i` is sampled only in the cycle of `start_i`. Changes to it during a search do not alter the search timing.
- R5: At step k (k=1..3), band bit 3−k is set to the inverse of `vco_fast_i` (1 means the VCO runs too fast). If k<3, the next lower bit is set to 1 as the new trial. `vco_fast_i` has no effect at steps 4 and 5, or between steps.
- R6: `busy_o` and `tune_hold_o` are always equal. Both fall on the edge of the 5th step, and they stay high before it.
- R7: While idle, `band_o` holds its value, and `ref_tick_i`, `vco_fast_i` and `div_sel_i` have no effect.
- R8: A `ref_tick_i` in the same cycle as `start_i` is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Divider-register write pulse; starts or restarts a search |
| ref_tick_i | input | 1 | One-cycle enable per reference-divider output edge |
| div_sel_i | input | 2 | Tick prescaler select |
| vco_fast_i | input | 1 | Comparator: 1 means the VCO is above target |
| band_o | output | 3 | Selected VCO band code |
| busy_o | output | 1 | Search in progress |
| tune_hold_o | output | 1 | Tuning node tied to the internal reference |

## Verification
`start_i` takes effect on the edge where it is sampled. Every band bit and the fall of `busy_o`/`tune_hold_o` also change on the edge that samples the R-th tick of a step. The bench therefore drives inputs on the falling edge and reads the outputs one nanosecond after each rising edge. After every tick it compares the outputs with a band and busy value that it rebuilds from its own count of ticks and steps. Random gaps, random divider changes and random comparator values between counted ticks make sure that a design which reacts to the wrong input or in the wrong cycle shows a mismatch at that same sample.

// File: rtl/bsel_pkg.sv
package bsel_pkg;
  // number of reference ticks per search step for a prescaler select code
  function automatic int unsigned div_ratio(input int unsigned sel);
    return 32'd1 << sel;
  endfunction

  // first trial code: only the top bit of the band set
  function automatic logic [7:0] trial_code(input int unsigned band_w);
    return 8'd1 << (band_w - 1);
  endfunction

  // one successive-approximation decision on bit idx
  function automatic logic [7:0] sar_next(input logic [7:0] band,
                                          input int unsigned idx,
                                          input logic fast);
    logic [7:0] nxt;
    nxt      = band;
    nxt[idx] = ~fast;
    if (idx > 0) nxt[idx-1] = 1'b1;
    return nxt;
  endfunction
endpackage

// File: rtl/bsel_prescaler.sv
module bsel_prescaler #(
  parameter int DIV_W = 2,
  localparam int CNT_W = (2 ** DIV_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic             tick,
  input  logic [DIV_W-1:0] sel,
  output logic             step
);
  import bsel_pkg::*;

  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last_tick;

  assign last_tick = (cnt_q == CNT_W'(div_ratio(int'(div_q)) - 1));
  assign step      = run && tick && !restart && last_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else if (restart) begin
      div_q <= sel;
      cnt_q <= '0;
    end else if (run && tick) begin
      cnt_q <= last_tick ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/bsel_seq.sv
module bsel_seq #(
  parameter int BAND_W = 3,
  localparam int N_STEPS = BAND_W + 2,
  localparam int PH_W = $clog2(N_STEPS),
  localparam int IDX_W = (BAND_W > 1) ? $clog2(BAND_W) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             step,
  output logic             busy,
  output logic             hold,
  output logic             sar_en,
  output logic [IDX_W-1:0] sar_idx,
  output logic             final_step
);
  logic [PH_W-1:0] phase_q;
  logic            busy_q;
  logic            hold_q;
  logic            live_step;

  assign live_step  = busy_q && step && !start;
  assign final_step = live_step && (phase_q == PH_W'(N_STEPS - 1));
  assign sar_en     = live_step && (phase_q < PH_W'(BAND_W));
  assign sar_idx    = IDX_W'(BAND_W - 1 - int'(phase_q));
  assign busy       = busy_q;
  assign hold       = hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b1;
      hold_q  <= 1'b1;
      phase_q <= '0;
    end else if (start) begin
      busy_q  <= 1'b1;
      hold_q  <= 1'b1;
      phase_q <= '0;
    end else if (final_step) begin
      busy_q  <= 1'b0;
      hold_q  <= 1'b0;
      phase_q <= '0;
    end else if (live_step) begin
      phase_q <= phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/bsel_sar.sv
module bsel_sar #(
  parameter int BAND_W = 3,
  localparam int IDX_W = (BAND_W > 1) ? $clog2(BAND_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              en,
  input  logic [IDX_W-1:0]  idx,
  input  logic              fast,
  output logic [BAND_W-1:0] band
);
  import bsel_pkg::*;

  logic [BAND_W-1:0] band_q;
  logic [BAND_W-1:0] trial;

  assign trial = BAND_W'(trial_code(BAND_W));
  assign band  = band_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     band_q <= trial;
    else if (load)  band_q <= trial;
    else if (en)    band_q <= BAND_W'(sar_next(8'(band_q), int'(idx), fast));
  end
endmodule

// File: rtl/bsel_top.sv
module bsel_top #(
  parameter int BAND_W = 3,
  parameter int DIV_W = 2,
  localparam int IDX_W = (BAND_W > 1) ? $clog2(BAND_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              ref_tick_i,
  input  logic [DIV_W-1:0]  div_sel_i,
  input  logic              vco_fast_i,
  output logic [BAND_W-1:0] band_o,
  output logic              busy_o,
  output logic              tune_hold_o
);
  logic             step_w;
  logic             busy_w;
  logic             hold_w;
  logic             sar_en_w;
  logic [IDX_W-1:0] sar_idx_w;
  logic             final_w;

  bsel_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(start_i), .run(busy_w),
    .tick(ref_tick_i), .sel(div_sel_i), .step(step_w)
  );

  bsel_seq #(.BAND_W(BAND_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start_i), .step(step_w),
    .busy(busy_w), .hold(hold_w), .sar_en(sar_en_w),
    .sar_idx(sar_idx_w), .final_step(final_w)
  );

  bsel_sar #(.BAND_W(BAND_W)) u_sar (
    .clk(clk), .rst_n(rst_n), .load(start_i), .en(sar_en_w),
    .idx(sar_idx_w), .fast(vco_fast_i), .band(band_o)
  );

  assign busy_o      = busy_w;
  assign tune_hold_o = hold_w;
endmodule

// File: rtl/bsel_checker.sv
module bsel_checker #(
  parameter int BAND_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              ref_tick_i,
  input logic [BAND_W-1:0] band_o,
  input logic              busy_o,
  input logic              tune_hold_o,
  input logic              step_w,
  input logic              sar_en_w,
  input logic              final_w
);
  localparam logic [BAND_W-1:0] TRIAL = BAND_W'(1) << (BAND_W - 1);

  a_r6_hold_matches_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o == tune_hold_o);

  a_r2_start_loads_trial: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> busy_o && tune_hold_o && band_o == TRIAL);

  a_r6_drop_only_on_final: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(final_w));

  a_r3_step_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    step_w |-> ref_tick_i && busy_o);

  a_r8_no_step_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !step_w);

  a_r7_idle_band_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && !start_i |=> $stable(band_o));

  a_r5_band_moves_only_on_decision: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i && !sar_en_w |=> $stable(band_o));
endmodule

bind bsel_top bsel_checker #(.BAND_W(BAND_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .ref_tick_i(ref_tick_i),
  .band_o(band_o), .busy_o(busy_o), .tune_hold_o(tune_hold_o),
  .step_w(step_w), .sar_en_w(sar_en_w), .final_w(final_w)
);

// File: tb/tb_bsel_top.sv
`timescale 1ns/1ps
module tb_bsel_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       ref_tick_i = 1'b0;
  logic [1:0] div_sel_i = 2'd0;
  logic       vco_fast_i = 1'b0;
  logic [2:0] band_o;
  logic       busy_o;
  logic       tune_hold_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  bsel_top dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ref_tick_i(ref_tick_i),
    .div_sel_i(div_sel_i), .vco_fast_i(vco_fast_i), .band_o(band_o),
    .busy_o(busy_o), .tune_hold_o(tune_hold_o)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bench model: ticks per step for a select code
  function automatic int ticks_per_step(input logic [1:0] sel);
    case (sel)
      2'b00: return 1;
      2'b01: return 2;
      2'b10: return 4;
      default: return 8;
    endcase
  endfunction

  // expected band after decision k (1..3) given comparator bits fb[2]..fb[0]
  function automatic logic [2:0] band_after(input int k, input logic [2:0] fb);
    logic [2:0] b;
    b = 3'b100;
    if (k >= 1) b = {~fb[2], 2'b10};
    if (k >= 2) b = {~fb[2], ~fb[1], 1'b1};
    if (k >= 3) b = ~fb;
    return b;
  endfunction

  task automatic pulse_start(input logic [1:0] sel, input bit tick_too);
    @(negedge clk);
    start_i = 1'b1; div_sel_i = sel; ref_tick_i = tick_too; vco_fast_i = 1'($urandom);
    @(posedge clk); #1;
    chk(busy_o && tune_hold_o && band_o == 3'b100, "R2", {busy_o, tune_hold_o, band_o}, 5'b11100);
    @(negedge clk);
    start_i = 1'b0; ref_tick_i = 1'b0;
  endtask

  task automatic run_search(input logic [1:0] sel, input logic [2:0] fb,
                            input bit use_start, input bit tick_on_start);
    int r;
    logic [2:0] exp_b;
    bit exp_busy;
    if (use_start) begin
      pulse_start(sel, tick_on_start);
      r = ticks_per_step(sel);
    end else begin
      r = 1;
    end
    for (int k = 1; k <= 5; k++) begin
      for (int j = 1; j <= r; j++) begin
        repeat ($urandom_range(0, 2)) begin
          @(negedge clk);
          ref_tick_i = 1'b0; div_sel_i = 2'($urandom); vco_fast_i = 1'($urandom);
        end
        @(negedge clk);
        ref_tick_i = 1'b1; div_sel_i = 2'($urandom);
        vco_fast_i = (j == r && k <= 3) ? fb[3-k] : 1'($urandom);
        @(posedge clk); #1;
        exp_b = band_after((j == r) ? k : k - 1, fb);
        chk(band_o == exp_b, "R5", band_o, exp_b);
        exp_busy = !(k == 5 && j == r);
        if (k == 5 && j == r)
          chk(busy_o == exp_busy && tune_hold_o == exp_busy, "R6",
              {busy_o, tune_hold_o}, {exp_busy, exp_busy});
        else
          chk(busy_o == exp_busy && tune_hold_o == exp_busy, "R3 R4 R8",
              {busy_o, tune_hold_o}, {exp_busy, exp_busy});
      end
    end
    @(negedge clk);
    ref_tick_i = 1'b0;
  endtask

  task automatic idle_check();
    logic [2:0] held;
    held = band_o;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      ref_tick_i = 1'($urandom); vco_fast_i = 1'($urandom); div_sel_i = 2'($urandom);
      @(posedge clk); #1;
      chk(band_o == held && !busy_o && !tune_hold_o, "R7", {busy_o, band_o}, {1'b0, held});
    end
    @(negedge clk);
    ref_tick_i = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd2024));
    div_sel_i = 2'b11;
    repeat (3) @(posedge clk);
    #1;
    chk(busy_o && tune_hold_o && band_o == 3'b100, "R1", {busy_o, tune_hold_o, band_o}, 5'b11100);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(busy_o && band_o == 3'b100, "R1", {busy_o, band_o}, 4'b1100);
    run_search(2'b00, 3'b011, 1'b0, 1'b0);   // R1: power-up search at divide-by-1
    idle_check();

    // directed: every divider code, distinct comparator patterns
    run_search(2'b00, 3'b000, 1'b1, 1'b0);
    run_search(2'b01, 3'b111, 1'b1, 1'b0);
    run_search(2'b10, 3'b101, 1'b1, 1'b1);   // R8: tick with start not counted
    run_search(2'b11, 3'b010, 1'b1, 1'b0);
    idle_check();

    // R2: restart in the middle of a search
    pulse_start(2'b10, 1'b0);
    repeat (6) begin
      @(negedge clk); ref_tick_i = 1'b1; vco_fast_i = 1'b1;
    end
    @(negedge clk); ref_tick_i = 1'b0;
    run_search(2'b01, 3'b110, 1'b1, 1'b0);
    idle_check();

    // random searches
    for (int n = 0; n < 16; n++) begin
      run_search(2'($urandom), 3'($urandom), 1'b1, 1'($urandom));
      if (n % 4 == 3) idle_check();
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule